// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

This block watches eight external input lines and turns a chosen edge on each line into a request to the processor. Each line first passes through two synchronising flops and one delay flop. The edge detector compares the newest synchronised sample with the one before it. A per-line polarity bit selects which edge counts. When the selected edge is seen, the block latches it in a sticky pending bit. Software must clear that bit by writing the flag register.

Each pending bit is qualified by a per-line enable bit, and the qualified bits are ORed into a single registered request line. The pending vector is also brought out directly, so a neighbouring priority or vectoring stage can decode which line fired. Software reaches the flag, enable and polarity registers through a small register bus. Writes take effect on the clock edge. Reads are combinational from the address.

Top module: `extint_ctrl`

## Requirements
- R1: A level change on `ext_pin[n]` that is first sampled at clock edge k sets `pending[n]` at edge k+2, so the bit is visible after edge k+2 and not before.
- R2: With polarity bit n at 0, only a low-to-high transition on line n sets its flag. With polarity bit n at 1, only a high-to-low transition sets it. The opposite transition leaves the flag unchanged.
- R3: A set flag stays at 1 until a flag-register write with a 0 in that bit, or a reset. Further edges and enable changes do not clear it.
- R4: `irq` is a register. After edge k+1 it equals the OR over n of (flag[n] AND enable[n]) as held after edge k. So it falls one cycle after the last enabled pending flag is cleared.
- R5: A flag is set by its edge even when its enable bit is 0. Setting the enable afterwards raises `irq` one cycle after the enable write.
- R6: A write to address 0 (flag register) loads `bus_wdata` into the flags: a 0 clears a bit and a 1 sets it. If a detected edge hits the same bit in the same cycle, the bit ends up set.
- R7: The register map is: address 0 flags, address 1 enables, address 2 polarity (1 = falling edge). Each reads back on `bus_rdata` exactly as last written. Address 3 reads 0, and writes to it change no register.
- R8: Synchronous reset clears the flag, enable and polarity registers, the synchroniser stages and `irq`. After reset every register reads 00h.
- R9: `pending` always equals the flag register as seen at address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin | input | 8 | Asynchronous external interrupt lines |
| bus_sel | input | 1 | Register bus access strobe |
| bus_wr | input | 1 | Write when high, read when low |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| irq | output | 1 | Registered interrupt request |
| pending | output | 8 | Sticky per-line flags |

## Verification
The assertions assume that the bus holds its request steady across each clock edge. They also assume that the external lines are low while reset is applied, because the synchroniser resets to low and a line that is high at reset would otherwise show as a rising edge. The stimulus changes every input only on the falling clock edge and keeps `ext_pin` at zero during reset. It then toggles the lines at random, with bursts of quiet cycles so that both edge kinds and long sticky periods occur. Random register writes are mixed in, including writes to the unused address and flag clears that land in the same cycle as an edge.

// File: rtl/extint_pkg.sv
package extint_pkg;

    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_FLAG = 2'd0,
        SEL_ENAB = 2'd1,
        SEL_POLR = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    // Decoded bus request for one cycle.
    typedef struct packed {
        logic wr_flag;
        logic wr_enab;
        logic wr_polr;
    } wr_dec_t;

    // Edge of interest for one line: pol=1 falling, pol=0 rising.
    function automatic logic edge_seen(input logic cur, input logic prev,
                                       input logic pol);
        return pol ? (prev & ~cur) : (cur & ~prev);
    endfunction

    function automatic wr_dec_t decode_write(input logic sel, input logic wr,
                                             input logic [ADDR_W-1:0] addr);
        wr_dec_t d;
        d.wr_flag = sel & wr & (addr == SEL_FLAG);
        d.wr_enab = sel & wr & (addr == SEL_ENAB);
        d.wr_polr = sel & wr & (addr == SEL_POLR);
        return d;
    endfunction

endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] pin_i,
    output logic [NUM_CH-1:0] sync_o,
    output logic [NUM_CH-1:0] dly_o
);
    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        logic meta_q, sync_q, dly_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
                dly_q  <= 1'b0;
            end else begin
                meta_q <= pin_i[n];
                sync_q <= meta_q;
                dly_q  <= sync_q;
            end
        end
        assign sync_o[n] = sync_q;
        assign dly_o[n]  = dly_q;
    end
endmodule

// File: rtl/extint_edge.sv
module extint_edge
    import extint_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic [NUM_CH-1:0] sync_i,
    input  logic [NUM_CH-1:0] dly_i,
    input  logic [NUM_CH-1:0] pol_i,
    output logic [NUM_CH-1:0] hit_o
);
    for (genvar n = 0; n < NUM_CH; n++) begin : g_det
        assign hit_o[n] = edge_seen(sync_i[n], dly_i[n], pol_i[n]);
    end
endmodule

// File: rtl/extint_regs.sv
module extint_regs
    import extint_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NUM_CH-1:0] bus_wdata,
    input  logic [NUM_CH-1:0] hit_i,
    output logic [NUM_CH-1:0] flag_o,
    output logic [NUM_CH-1:0] en_o,
    output logic [NUM_CH-1:0] pol_o,
    output logic              irq_o,
    output logic [NUM_CH-1:0] rdata_o
);
    wr_dec_t           dec;
    logic [NUM_CH-1:0] flag_q, en_q, pol_q, flag_d;
    logic              irq_q;

    assign dec = decode_write(bus_sel, bus_wr, bus_addr);

    // Software load first, hardware set on top so a coincident edge survives.
    always_comb begin
        flag_d = dec.wr_flag ? bus_wdata : flag_q;
        flag_d = flag_d | hit_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= '0;
            en_q   <= '0;
            pol_q  <= '0;
            irq_q  <= 1'b0;
        end else begin
            flag_q <= flag_d;
            if (dec.wr_enab) en_q  <= bus_wdata;
            if (dec.wr_polr) pol_q <= bus_wdata;
            irq_q  <= |(flag_q & en_q);
        end
    end

    always_comb begin
        unique case (reg_sel_e'(bus_addr))
            SEL_FLAG: rdata_o = flag_q;
            SEL_ENAB: rdata_o = en_q;
            SEL_POLR: rdata_o = pol_q;
            default:  rdata_o = '0;
        endcase
    end

    assign flag_o = flag_q;
    assign en_o   = en_q;
    assign pol_o  = pol_q;
    assign irq_o  = irq_q;
endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl
    import extint_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] ext_pin,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NUM_CH-1:0] bus_wdata,
    output logic [NUM_CH-1:0] bus_rdata,
    output logic              irq,
    output logic [NUM_CH-1:0] pending
);
    logic [NUM_CH-1:0] sync_s, dly_s, hit, en_q, pol_q;

    extint_sync #(.NUM_CH(NUM_CH)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (ext_pin),
        .sync_o (sync_s),
        .dly_o  (dly_s)
    );

    extint_edge #(.NUM_CH(NUM_CH)) u_edge (
        .sync_i (sync_s),
        .dly_i  (dly_s),
        .pol_i  (pol_q),
        .hit_o  (hit)
    );

    extint_regs #(.NUM_CH(NUM_CH)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .hit_i     (hit),
        .flag_o    (pending),
        .en_o      (en_q),
        .pol_o     (pol_q),
        .irq_o     (irq),
        .rdata_o   (bus_rdata)
    );
endmodule

// File: rtl/extint_ctrl_chk.sv
module extint_ctrl_chk #(
    parameter int NUM_CH = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [1:0]        bus_addr,
    input logic [NUM_CH-1:0] bus_wdata,
    input logic [NUM_CH-1:0] bus_rdata,
    input logic              irq,
    input logic [NUM_CH-1:0] pending,
    input logic [NUM_CH-1:0] en_q,
    input logic [NUM_CH-1:0] hit
);
    logic flag_wr;
    assign flag_wr = bus_sel & bus_wr & (bus_addr == 2'd0);

    assert_reset_clears_R8: assert property (@(posedge clk)
        rst |=> (pending == '0) && !irq);

    assert_irq_tracks_R4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq == $past(|(pending & en_q))));

    assert_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        !flag_wr |=> ((pending & $past(pending)) == $past(pending)));

    assert_set_only_by_edge_R2: assert property (@(posedge clk) disable iff (rst)
        !flag_wr |=> ((pending & ~$past(pending) & ~$past(hit)) == '0));

    assert_edge_wins_R6: assert property (@(posedge clk) disable iff (rst)
        flag_wr |=> (pending == ($past(bus_wdata) | $past(hit))));

    assert_unused_reads_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 2'd3) |-> (bus_rdata == '0));

    assert_pending_visible_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 2'd0) |-> (bus_rdata == pending));
endmodule

bind extint_ctrl extint_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .pending   (pending),
    .en_q      (en_q),
    .hit       (hit)
);

// File: tb/extint_ctrl_test.sv
module extint_ctrl_test;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] ext_pin = '0;
    logic         bus_sel = 1'b0;
    logic         bus_wr = 1'b0;
    logic [1:0]   bus_addr = 2'd0;
    logic [N-1:0] bus_wdata = '0;
    logic [N-1:0] bus_rdata;
    logic         irq;
    logic [N-1:0] pending;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    string tag = "R9";

    always #2.5 clk = ~clk;

    extint_ctrl #(.NUM_CH(N)) uut (
        .clk(clk), .rst(rst), .ext_pin(ext_pin), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq), .pending(pending)
    );

    // Reference state built from the requirements.
    logic [N-1:0] m_p1, m_p2, m_p3, m_flag, m_en, m_pol;
    logic         m_irq;

    function automatic logic [N-1:0] want_hit(input logic [N-1:0] cur,
            input logic [N-1:0] prev, input logic [N-1:0] pol);
        return (pol & prev & ~cur) | (~pol & cur & ~prev);
    endfunction

    function automatic logic [N-1:0] want_read(input logic [1:0] a);
        case (a)
            2'd0: return m_flag;
            2'd1: return m_en;
            2'd2: return m_pol;
            default: return '0;
        endcase
    endfunction

    always @(posedge clk) begin
        logic [N-1:0] h, nf;
        if (rst) begin
            m_p1 = '0; m_p2 = '0; m_p3 = '0;
            m_flag = '0; m_en = '0; m_pol = '0; m_irq = 1'b0;
        end else begin
            h  = want_hit(m_p2, m_p3, m_pol);
            nf = (bus_sel && bus_wr && bus_addr == 2'd0) ? bus_wdata : m_flag;
            nf = nf | h;
            m_irq = |(m_flag & m_en);
            if (bus_sel && bus_wr && bus_addr == 2'd1) m_en  = bus_wdata;
            if (bus_sel && bus_wr && bus_addr == 2'd2) m_pol = bus_wdata;
            m_flag = nf;
            m_p3 = m_p2; m_p2 = m_p1; m_p1 = ext_pin;
        end
    end

    task automatic chk(input string t, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", t, act, exp, $time);
        end
    endtask

    // Compare outputs to the reference, then drive the next cycle's inputs.
    task automatic step(input logic [N-1:0] pins, input logic sel,
                        input logic wr, input logic [1:0] a,
                        input logic [N-1:0] d);
        @(negedge clk);
        chk({tag, " R9 pending"}, pending, m_flag);
        chk({tag, " R4 irq"}, irq, m_irq);
        chk({tag, " R7 read"}, bus_rdata, want_read(bus_addr));
        ext_pin = pins; bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(ext_pin, 1'b0, 1'b0, bus_addr, '0);
    endtask

    task automatic wreg(input logic [1:0] a, input logic [N-1:0] d);
        step(ext_pin, 1'b1, 1'b1, a, d);
        step(ext_pin, 1'b0, 1'b0, a, '0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R8: reset state of every register
        tag = "R8";
        for (int a = 0; a < 4; a++) begin
            step('0, 1'b0, 1'b0, a[1:0], '0);
            @(negedge clk);
            chk("R8 reset read", bus_rdata, 32'h0);
        end
        chk("R8 irq after reset", irq, 1'b0);

        // R1: latency - pin rises before edge k, pending at k+2
        tag = "R1";
        step(8'h01, 1'b0, 1'b0, 2'd0, '0);   // sampled at next edge k
        @(negedge clk); chk("R1 not yet (k)", pending[0], 1'b0);
        @(negedge clk); chk("R1 not yet (k+1)", pending[0], 1'b0);
        @(negedge clk); chk("R1 set at k+2", pending[0], 1'b1);
        idle(2);

        // R3 + R5: flag sticky with enable 0, then enable raises irq
        tag = "R5";
        step(8'h00, 1'b0, 1'b0, 2'd0, '0);
        idle(4);
        chk("R3 sticky after fall", pending[0], 1'b1);
        chk("R5 no irq while disabled", irq, 1'b0);
        step(ext_pin, 1'b1, 1'b1, 2'd1, 8'h01);
        step(ext_pin, 1'b0, 1'b0, 2'd1, '0);
        @(negedge clk); chk("R5 irq after enable", irq, 1'b1);

        // R4: clear drops irq one cycle later
        tag = "R4";
        wreg(2'd0, 8'h00);
        @(negedge clk); chk("R4 irq low after clear", irq, 1'b0);

        // R2: falling polarity on line 1; rising must not set it
        tag = "R2";
        wreg(2'd2, 8'h02);
        step(8'h02, 1'b0, 1'b0, 2'd0, '0);
        idle(4);
        chk("R2 rise ignored with falling polarity", pending[1], 1'b0);
        step(8'h00, 1'b0, 1'b0, 2'd0, '0);
        idle(4);
        chk("R2 fall sets flag", pending[1], 1'b1);

        // R6: clear coinciding with an edge on line 2 (rising) keeps it set
        tag = "R6";
        wreg(2'd0, 8'h00);
        step(8'h04, 1'b0, 1'b0, 2'd0, '0);   // sampled at edge k
        step(8'h04, 1'b0, 1'b0, 2'd0, '0);   // edge k passes
        step(8'h04, 1'b1, 1'b1, 2'd0, 8'h00); // write lands on edge k+2
        step(8'h04, 1'b0, 1'b0, 2'd0, '0);
        chk("R6 edge wins over clear", pending[2], 1'b1);
        wreg(2'd0, 8'h80);
        @(negedge clk); chk("R6 software set", pending, 32'h80);

        // R7: unused address writes change nothing
        tag = "R7";
        wreg(2'd3, 8'hFF);
        step(ext_pin, 1'b0, 1'b0, 2'd1, '0);
        @(negedge clk); chk("R7 enable untouched", bus_rdata, 32'h01);
        step(ext_pin, 1'b0, 1'b0, 2'd2, '0);
        @(negedge clk); chk("R7 polarity untouched", bus_rdata, 32'h02);
        step(ext_pin, 1'b0, 1'b0, 2'd3, '0);
        @(negedge clk); chk("R7 unused reads zero", bus_rdata, 32'h0);

        // Random mix: pins, writes, reads
        tag = "R3";
        for (int i = 0; i < 3000; i++) begin
            logic [N-1:0] p;
            logic s, w;
            p = ((i % 50) < 35) ? N'($urandom) : ext_pin;
            s = ($urandom % 4) == 0;
            w = $urandom % 2;
            step(p, s, w, 2'($urandom), N'($urandom));
        end
        idle(2);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule